// File: doc/BRIEF.md
# Tiled Matrix-Multiply Address Scheduler

This controller sequences the memory traffic for C = A·B + C on matrices of any size. It cuts the result into tiles of at most SI rows by SJ columns and walks them in order. A tile advances one row-block at a time, and the tiles inside a row-block go from left to right. Each tile goes through three phases:

- The C tile is read into the processing array.
- For every step of the inner dimension, one column of A and one row of B are streamed.
- The C tile is written back.

All three phases share one word-wide memory port. The port carries one access per cycle, and each access is tagged with its purpose. Every address is formed from additions only. This includes the row-block strides, which are built up during a short setup phase after start.

Two tiles of C storage are modelled in the array. While one tile is computing, the previous tile's results can drain and the next tile's C data can be fetched, on any cycle the compute stream leaves the port free. The processing array paces the compute stream through a single ready input.

All matrices are row-major. The leading dimension of A is k, of B is n, and of C is n. The dimensions m, n and k must each be at least one.

Top module: `mmsched_top`

## Requirements
- R1: Tiles are visited row-block by row-block, and left to right within a row-block. Each tile has row count min(SI, m − row0) and column count min(SJ, n − col0).
- R2: C loads carry kind code 0 and no write. They read each tile row by row, left to right, at address c_base + r·n + col.
- R3: For each inner step kk from 0 to k−1, the block issues the tile's A column top to bottom (kind 1, address a_base + r·k + kk) and then the tile's B row left to right (kind 2, address b_base + kk·n + col).
- R4: C stores carry kind code 3 with the write flag set. They write each tile's words in the same order as its loads.
- R5: No access falls outside the matrix addressed by its kind.
- R6: At most one access is issued per cycle. A/B accesses take the port before stores, and stores take it before loads. While the array is ready, a tile's A/B accesses come on back-to-back cycles.
- R7: Stores of the previous tile and loads of the next tile fill cycles left free inside a tile's compute stream. The load of tile t+2 begins only after the last store of tile t.
- R8: No A/B access is issued in a cycle where pe_ready is low. The stream resumes with no word lost or repeated.
- R9: done is low from reset and in the cycle after an accepted start. It rises only after the last store of the last tile, stays high until the next start, and no access is issued while it is high.
- R10: A start pulse that arrives while a job is running has no effect on the job's traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle job start, accepted only when idle |
| a_base | input | AW | Base word address of A |
| b_base | input | AW | Base word address of B |
| c_base | input | AW | Base word address of C |
| m_dim | input | DW | Rows of A and C |
| n_dim | input | DW | Columns of B and C |
| k_dim | input | DW | Columns of A, rows of B |
| pe_ready | input | 1 | Array can accept an A/B word this cycle |
| mem_valid | output | 1 | An access is issued this cycle |
| mem_write | output | 1 | The access is a write |
| mem_addr | output | AW | Word address of the access |
| mem_kind | output | 2 | 0 C load, 1 A read, 2 B read, 3 C store |
| done | output | 1 | Job complete, held until next start |

## Verification
The bench targets ragged edges in both directions at once, a single-word job, and a run where the array withholds ready every third cycle. If the edge clipping were wrong, the design would issue words beyond the last row or column, and the stream comparison and the range check would both see it. If the priority were inverted, stores would split a tile's A/B burst. If the overlap were missing, no store or load would fall inside a compute window. If the buffer limit were broken, a tile's load would start before the store of the tile two places back had ended. A start pulse injected mid-job with different sizes would change the issued addresses on a design that did not ignore it.

// File: rtl/mmsched_pkg.sv
// Shared definitions for the tiled matrix-multiply scheduler.
// Assumes: memory accesses are tagged with one of four purposes.
package mmsched_pkg;
    typedef enum logic [1:0] {
        KIND_CLOAD  = 2'd0,
        KIND_AREAD  = 2'd1,
        KIND_BREAD  = 2'd2,
        KIND_CSTORE = 2'd3
    } mem_kind_e;
endpackage

// File: rtl/mmsched_tiler.sv
// Tile walker: after start, builds the row-block strides SI*k and SI*n by
// repeated addition, then offers one tile descriptor at a time (bases and
// clipped extents). Assumes m, n, k >= 1.
module mmsched_tiler #(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int SI = 4,
    parameter int SJ = 4,
    parameter int RW = 3,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [AW-1:0] a_base_i,
    input  logic [AW-1:0] b_base_i,
    input  logic [AW-1:0] c_base_i,
    input  logic [DW-1:0] m_i,
    input  logic [DW-1:0] n_i,
    input  logic [DW-1:0] k_i,
    input  logic          take,
    output logic          t_valid,
    output logic [AW-1:0] t_a,
    output logic [AW-1:0] t_b,
    output logic [AW-1:0] t_c,
    output logic [RW-1:0] t_rows,
    output logic [CW-1:0] t_cols,
    output logic          t_last,
    output logic [DW-1:0] n_q,
    output logic [DW-1:0] k_q
);
    localparam int SCW = $clog2(SI + 1);

    logic           active;
    logic [SCW-1:0] setup_cnt;
    logic [AW-1:0]  b_q, a_blk, c_blk, a_rb, c_rb, c_ptr, b_ptr;
    logic [DW-1:0]  rem_r, rem_c;
    logic           row_end, blk_last;

    // Tile edge tests against the remaining extents
    always_comb begin
        row_end  = rem_c <= DW'(SJ);
        blk_last = rem_r <= DW'(SI);
        t_valid  = active && (setup_cnt == '0);
        t_a      = a_rb;
        t_b      = b_ptr;
        t_c      = c_ptr;
        t_rows   = blk_last ? RW'(rem_r) : RW'(SI);
        t_cols   = row_end ? CW'(rem_c) : CW'(SJ);
        t_last   = row_end && blk_last;
    end

    // Setup accumulation, then tile-to-tile advance by addition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            setup_cnt <= '0;
            b_q <= '0; a_blk <= '0; c_blk <= '0;
            a_rb <= '0; c_rb <= '0; c_ptr <= '0; b_ptr <= '0;
            rem_r <= '0; rem_c <= '0; n_q <= '0; k_q <= '0;
        end else if (go) begin
            active    <= 1'b1;
            setup_cnt <= SCW'(SI);
            b_q   <= b_base_i;
            a_blk <= '0;
            c_blk <= '0;
            a_rb  <= a_base_i;
            c_rb  <= c_base_i;
            c_ptr <= c_base_i;
            b_ptr <= b_base_i;
            rem_r <= m_i;
            rem_c <= n_i;
            n_q   <= n_i;
            k_q   <= k_i;
        end else if (active && setup_cnt != '0) begin
            a_blk     <= a_blk + AW'(k_q);
            c_blk     <= c_blk + AW'(n_q);
            setup_cnt <= setup_cnt - 1'b1;
        end else if (t_valid && take) begin
            if (!row_end) begin
                rem_c <= rem_c - DW'(SJ);
                c_ptr <= c_ptr + AW'(SJ);
                b_ptr <= b_ptr + AW'(SJ);
            end else if (!blk_last) begin
                rem_r <= rem_r - DW'(SI);
                rem_c <= n_q;
                a_rb  <= a_rb + a_blk;
                c_rb  <= c_rb + c_blk;
                c_ptr <= c_rb + c_blk;
                b_ptr <= b_q;
            end else begin
                active <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mmsched_ctile.sv
// C tile mover: walks one tile row by row (stride = row length of C),
// one word per grant. Used for both the load and the store phase.
// Assumes rows and cols >= 1 at start.
module mmsched_ctile #(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int RW = 3,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] base,
    input  logic [RW-1:0] rows,
    input  logic [CW-1:0] cols,
    input  logic [DW-1:0] stride,
    input  logic          gnt,
    output logic          req,
    output logic [AW-1:0] addr,
    output logic          fin
);
    logic          busy;
    logic [AW-1:0] row_q;
    logic [RW-1:0] r_cnt, rows_q;
    logic [CW-1:0] c_cnt, cols_q;
    logic [DW-1:0] stride_q;
    logic          last_c, last_r;

    // Position tests for the final beat
    always_comb begin
        last_c = c_cnt == cols_q - 1'b1;
        last_r = r_cnt == rows_q - 1'b1;
        req    = busy;
        fin    = gnt && last_c && last_r;
    end

    // Address walk: +1 along a row, +stride to the next row
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; addr <= '0; row_q <= '0;
            r_cnt <= '0; c_cnt <= '0; rows_q <= '0; cols_q <= '0; stride_q <= '0;
        end else if (start) begin
            busy <= 1'b1; addr <= base; row_q <= base;
            r_cnt <= '0; c_cnt <= '0;
            rows_q <= rows; cols_q <= cols; stride_q <= stride;
        end else if (gnt) begin
            if (last_c) begin
                if (last_r) begin
                    busy <= 1'b0;
                end else begin
                    row_q <= row_q + AW'(stride_q);
                    addr  <= row_q + AW'(stride_q);
                    r_cnt <= r_cnt + 1'b1;
                    c_cnt <= '0;
                end
            end else begin
                addr  <= addr + 1'b1;
                c_cnt <= c_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mmsched_exec.sv
// Compute streamer: for each inner step, one A column (stride k) then one
// B row (stride 1); moves the column by +1 and the row by +n per step.
// Assumes rows, cols, k >= 1 at start.
module mmsched_exec #(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int RW = 3,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] a_base,
    input  logic [AW-1:0] b_base,
    input  logic [RW-1:0] rows,
    input  logic [CW-1:0] cols,
    input  logic [DW-1:0] k_dim,
    input  logic [DW-1:0] n_dim,
    input  logic          gnt,
    output logic          busy,
    output logic [AW-1:0] addr,
    output logic          is_b,
    output logic          fin
);
    logic [AW-1:0] a_col, b_row;
    logic [RW-1:0] r_idx, rows_q;
    logic [CW-1:0] c_idx, cols_q;
    logic [DW-1:0] kk, k_q, n_q;
    logic          last_r, last_c, last_k;

    // End-of-segment and end-of-tile tests
    always_comb begin
        last_r = r_idx == rows_q - 1'b1;
        last_c = c_idx == cols_q - 1'b1;
        last_k = kk == k_q - 1'b1;
        fin    = gnt && is_b && last_c && last_k;
    end

    // Alternating A-column / B-row address walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; addr <= '0; is_b <= 1'b0;
            a_col <= '0; b_row <= '0; r_idx <= '0; c_idx <= '0;
            rows_q <= '0; cols_q <= '0; kk <= '0; k_q <= '0; n_q <= '0;
        end else if (start) begin
            busy <= 1'b1; addr <= a_base; is_b <= 1'b0;
            a_col <= a_base; b_row <= b_base; r_idx <= '0; c_idx <= '0;
            rows_q <= rows; cols_q <= cols; kk <= '0; k_q <= k_dim; n_q <= n_dim;
        end else if (gnt) begin
            if (!is_b) begin
                if (last_r) begin
                    is_b  <= 1'b1;
                    r_idx <= '0;
                    addr  <= b_row;
                end else begin
                    r_idx <= r_idx + 1'b1;
                    addr  <= addr + AW'(k_q);
                end
            end else if (last_c) begin
                c_idx <= '0;
                if (last_k) begin
                    busy <= 1'b0;
                end else begin
                    kk    <= kk + 1'b1;
                    a_col <= a_col + 1'b1;
                    b_row <= b_row + AW'(n_q);
                    addr  <= a_col + 1'b1;
                    is_b  <= 1'b0;
                end
            end else begin
                c_idx <= c_idx + 1'b1;
                addr  <= addr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mmsched_top.sv
// Tiled matrix-multiply scheduler: tile walker feeding a load slot, a
// compute slot and a store slot, all sharing one memory port with fixed
// priority compute > store > load. At most two tiles hold C storage.
// Assumes m, n, k >= 1 and all addresses fit in AW bits.
module mmsched_top
    import mmsched_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int SI = 4,
    parameter int SJ = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] a_base,
    input  logic [AW-1:0] b_base,
    input  logic [AW-1:0] c_base,
    input  logic [DW-1:0] m_dim,
    input  logic [DW-1:0] n_dim,
    input  logic [DW-1:0] k_dim,
    input  logic          pe_ready,
    output logic          mem_valid,
    output logic          mem_write,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_kind,
    output logic          done
);
    localparam int RW = $clog2(SI + 1);
    localparam int CW = $clog2(SJ + 1);

    logic          busy_r, done_r, go;
    logic          tl_valid, tl_last;
    logic [AW-1:0] tl_a, tl_b, tl_c;
    logic [RW-1:0] tl_rows;
    logic [CW-1:0] tl_cols;
    logic [DW-1:0] n_q, k_q;

    logic          ld_full, ld_loaded, ld_last;
    logic [AW-1:0] ld_a, ld_b, ld_c;
    logic [RW-1:0] ld_rows;
    logic [CW-1:0] ld_cols;
    logic          ex_full, ex_done, ex_last;
    logic [AW-1:0] ex_c;
    logic [RW-1:0] ex_rows;
    logic [CW-1:0] ex_cols;
    logic          st_full, st_last;
    logic [1:0]    occ;

    logic          ld_take, ex_take, st_take;
    logic          ld_req, st_req, ex_busy, ex_req;
    logic          gnt_ld, gnt_st, gnt_ex;
    logic          ld_fin, st_fin, ex_fin, ex_isb;
    logic [AW-1:0] ld_addr, st_addr, ex_addr;
    mem_kind_e     kind;

    assign go = start && !busy_r;

    mmsched_tiler #(.AW(AW), .DW(DW), .SI(SI), .SJ(SJ), .RW(RW), .CW(CW)) tiler_i (
        .clk(clk), .rst_n(rst_n), .go(go),
        .a_base_i(a_base), .b_base_i(b_base), .c_base_i(c_base),
        .m_i(m_dim), .n_i(n_dim), .k_i(k_dim), .take(ld_take),
        .t_valid(tl_valid), .t_a(tl_a), .t_b(tl_b), .t_c(tl_c),
        .t_rows(tl_rows), .t_cols(tl_cols), .t_last(tl_last),
        .n_q(n_q), .k_q(k_q)
    );

    mmsched_ctile #(.AW(AW), .DW(DW), .RW(RW), .CW(CW)) load_i (
        .clk(clk), .rst_n(rst_n), .start(ld_take), .base(tl_c),
        .rows(tl_rows), .cols(tl_cols), .stride(n_q), .gnt(gnt_ld),
        .req(ld_req), .addr(ld_addr), .fin(ld_fin)
    );

    mmsched_exec #(.AW(AW), .DW(DW), .RW(RW), .CW(CW)) exec_i (
        .clk(clk), .rst_n(rst_n), .start(ex_take), .a_base(ld_a), .b_base(ld_b),
        .rows(ld_rows), .cols(ld_cols), .k_dim(k_q), .n_dim(n_q), .gnt(gnt_ex),
        .busy(ex_busy), .addr(ex_addr), .is_b(ex_isb), .fin(ex_fin)
    );

    mmsched_ctile #(.AW(AW), .DW(DW), .RW(RW), .CW(CW)) store_i (
        .clk(clk), .rst_n(rst_n), .start(st_take), .base(ex_c),
        .rows(ex_rows), .cols(ex_cols), .stride(n_q), .gnt(gnt_st),
        .req(st_req), .addr(st_addr), .fin(st_fin)
    );

    // Slot hand-off conditions; load also waits for a free C buffer
    always_comb begin
        ld_take = busy_r && tl_valid && !ld_full && (occ < 2'd2);
        ex_take = ld_full && ld_loaded && !ex_full;
        st_take = ex_full && ex_done && !st_full;
    end

    // Fixed-priority port arbiter: compute, then store, then load
    always_comb begin
        ex_req    = ex_busy && pe_ready;
        gnt_ex    = ex_req;
        gnt_st    = st_req && !ex_req;
        gnt_ld    = ld_req && !ex_req && !st_req;
        mem_valid = gnt_ex || gnt_st || gnt_ld;
        mem_write = gnt_st;
        if (gnt_ex) begin
            mem_addr = ex_addr;
            kind     = ex_isb ? KIND_BREAD : KIND_AREAD;
        end else if (gnt_st) begin
            mem_addr = st_addr;
            kind     = KIND_CSTORE;
        end else begin
            mem_addr = ld_addr;
            kind     = KIND_CLOAD;
        end
        mem_kind = kind;
    end

    // Slot occupancy and descriptor hand-over between phases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_full <= 1'b0; ld_loaded <= 1'b0; ld_last <= 1'b0;
            ld_a <= '0; ld_b <= '0; ld_c <= '0; ld_rows <= '0; ld_cols <= '0;
            ex_full <= 1'b0; ex_done <= 1'b0; ex_last <= 1'b0;
            ex_c <= '0; ex_rows <= '0; ex_cols <= '0;
            st_full <= 1'b0; st_last <= 1'b0; occ <= '0;
        end else begin
            if (ld_take) begin
                ld_full <= 1'b1; ld_loaded <= 1'b0;
                ld_a <= tl_a; ld_b <= tl_b; ld_c <= tl_c;
                ld_rows <= tl_rows; ld_cols <= tl_cols; ld_last <= tl_last;
            end else if (ex_take) begin
                ld_full <= 1'b0;
            end else if (ld_fin) begin
                ld_loaded <= 1'b1;
            end
            if (ex_take) begin
                ex_full <= 1'b1; ex_done <= 1'b0;
                ex_c <= ld_c; ex_rows <= ld_rows; ex_cols <= ld_cols; ex_last <= ld_last;
            end else if (st_take) begin
                ex_full <= 1'b0;
            end else if (ex_fin) begin
                ex_done <= 1'b1;
            end
            if (st_take) begin
                st_full <= 1'b1; st_last <= ex_last;
            end else if (st_fin) begin
                st_full <= 1'b0;
            end
            occ <= occ + {1'b0, ld_take} - {1'b0, st_fin};
        end
    end

    // Job state: accept start when idle, finish on the last store
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_r <= 1'b0;
            done_r <= 1'b0;
        end else if (go) begin
            busy_r <= 1'b1;
            done_r <= 1'b0;
        end else if (st_fin && st_last) begin
            busy_r <= 1'b0;
            done_r <= 1'b1;
        end
    end

    assign done = done_r;
endmodule

// File: rtl/mmsched_chk.sv
// Property checker for mmsched_top, attached by bind below. Latches the
// job geometry on an accepted start and checks port-level rules.
module mmsched_chk
    import mmsched_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          pe_ready,
    input logic          ex_req,
    input logic          st_req,
    input logic          mem_valid,
    input logic [AW-1:0] mem_addr,
    input logic [1:0]    mem_kind,
    input logic [AW-1:0] a_base,
    input logic [AW-1:0] b_base,
    input logic [AW-1:0] c_base,
    input logic [DW-1:0] m_dim,
    input logic [DW-1:0] n_dim,
    input logic [DW-1:0] k_dim
);
    logic [AW-1:0] a_q, b_q, c_q, a_len, b_len, c_len;

    // Capture the accepted job's geometry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0; b_q <= '0; c_q <= '0; a_len <= '0; b_len <= '0; c_len <= '0;
        end else if (start && !busy) begin
            a_q <= a_base; b_q <= b_base; c_q <= c_base;
            a_len <= AW'(m_dim * k_dim);
            b_len <= AW'(k_dim * n_dim);
            c_len <= AW'(m_dim * n_dim);
        end
    end

    AST_EXEC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ex_req |-> mem_valid && (mem_kind == KIND_AREAD || mem_kind == KIND_BREAD)); // R6
    AST_STORE_OVER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && !ex_req) |-> mem_valid && mem_kind == KIND_CSTORE); // R6
    AST_STALL_RESPECT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && (mem_kind == KIND_AREAD || mem_kind == KIND_BREAD)) |-> pe_ready); // R8
    AST_A_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_kind == KIND_AREAD) |-> (mem_addr >= a_q && mem_addr < a_q + a_len)); // R5
    AST_B_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_kind == KIND_BREAD) |-> (mem_addr >= b_q && mem_addr < b_q + b_len)); // R5
    AST_C_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && (mem_kind == KIND_CLOAD || mem_kind == KIND_CSTORE))
        |-> (mem_addr >= c_q && mem_addr < c_q + c_len)); // R5
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R9
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_valid); // R9
endmodule

bind mmsched_top mmsched_chk #(.AW(AW), .DW(DW)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy_r), .done(done),
    .pe_ready(pe_ready), .ex_req(ex_req), .st_req(st_req),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_kind(mem_kind),
    .a_base(a_base), .b_base(b_base), .c_base(c_base),
    .m_dim(m_dim), .n_dim(n_dim), .k_dim(k_dim)
);

// File: tb/mmsched_tb_top.sv
// Directed bench for mmsched_top: each scenario task starts a job, logs
// the port traffic and compares it with streams built from the requirements.
module mmsched_tb_top;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam int SI = 4;
    localparam int SJ = 4;
    localparam int LN = 1024;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] a_base = '0, b_base = '0, c_base = '0;
    logic [DW-1:0] m_dim = '0, n_dim = '0, k_dim = '0;
    logic          pe_ready = 1'b1;
    logic          mem_valid, mem_write, done;
    logic [AW-1:0] mem_addr;
    logic [1:0]    mem_kind;

    always #2 clk = ~clk;

    mmsched_top #(.AW(AW), .DW(DW), .SI(SI), .SJ(SJ)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_base(a_base), .b_base(b_base), .c_base(c_base),
        .m_dim(m_dim), .n_dim(n_dim), .k_dim(k_dim), .pe_ready(pe_ready),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_kind(mem_kind), .done(done)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    int exp_c[LN], exp_ab[LN], exp_abk[LN];
    int t_cf[64], t_cn[64], t_abf[64], t_abn[64];
    int n_exp_c, n_exp_ab, n_tiles;
    int lg_c[LN], lg_ccyc[LN], lg_s[LN], lg_scyc[LN];
    int lg_ab[LN], lg_abk[LN], lg_abcyc[LN];
    int nlc, nls, nlab, stall_viol, done_beats, wr_bad, range_bad;
    int ra, rb, rc, ra_len, rb_len, rc_len;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Port monitor, sampled mid-cycle
    always @(negedge clk) begin
        cyc++;
        if (mem_valid) begin
            if (done) done_beats++;
            if (mem_write != (mem_kind == 2'd3)) wr_bad++;
            case (mem_kind)
                2'd0: begin
                    if (int'(mem_addr) < rc || int'(mem_addr) >= rc + rc_len) range_bad++;
                    if (nlc < LN) begin lg_c[nlc] = int'(mem_addr); lg_ccyc[nlc] = cyc; nlc++; end
                end
                2'd3: begin
                    if (int'(mem_addr) < rc || int'(mem_addr) >= rc + rc_len) range_bad++;
                    if (nls < LN) begin lg_s[nls] = int'(mem_addr); lg_scyc[nls] = cyc; nls++; end
                end
                default: begin
                    if (!pe_ready) stall_viol++;
                    if (mem_kind == 2'd1 && (int'(mem_addr) < ra || int'(mem_addr) >= ra + ra_len)) range_bad++;
                    if (mem_kind == 2'd2 && (int'(mem_addr) < rb || int'(mem_addr) >= rb + rb_len)) range_bad++;
                    if (nlab < LN) begin
                        lg_ab[nlab] = int'(mem_addr); lg_abk[nlab] = int'(mem_kind);
                        lg_abcyc[nlab] = cyc; nlab++;
                    end
                end
            endcase
        end
    end

    // Expected streams from the tiling rules
    task automatic build(input int m, input int n, input int k, input int a, input int b, input int c);
        n_exp_c = 0; n_exp_ab = 0; n_tiles = 0;
        for (int i0 = 0; i0 < m; i0 += SI) begin
            for (int j0 = 0; j0 < n; j0 += SJ) begin
                int rows, cols;
                rows = (m - i0 < SI) ? m - i0 : SI;
                cols = (n - j0 < SJ) ? n - j0 : SJ;
                t_cf[n_tiles] = n_exp_c; t_cn[n_tiles] = rows * cols;
                for (int r = 0; r < rows; r++)
                    for (int cc = 0; cc < cols; cc++) begin
                        exp_c[n_exp_c] = c + (i0 + r) * n + j0 + cc; n_exp_c++;
                    end
                t_abf[n_tiles] = n_exp_ab; t_abn[n_tiles] = (rows + cols) * k;
                for (int kk = 0; kk < k; kk++) begin
                    for (int r = 0; r < rows; r++) begin
                        exp_ab[n_exp_ab] = a + (i0 + r) * k + kk; exp_abk[n_exp_ab] = 1; n_exp_ab++;
                    end
                    for (int cc = 0; cc < cols; cc++) begin
                        exp_ab[n_exp_ab] = b + kk * n + j0 + cc; exp_abk[n_exp_ab] = 2; n_exp_ab++;
                    end
                end
                n_tiles++;
            end
        end
    endtask

    // Compare every logged stream with its expectation
    task automatic compare_streams(input string tag);
        int bad_i, act, expv;
        chk(nlc == n_exp_c, {tag, " R1 R2 load count"}, nlc, n_exp_c);
        bad_i = -1;
        for (int i = 0; i < n_exp_c && i < nlc; i++) if (bad_i < 0 && lg_c[i] != exp_c[i]) bad_i = i;
        act = (bad_i < 0) ? 0 : lg_c[bad_i]; expv = (bad_i < 0) ? 0 : exp_c[bad_i];
        chk(bad_i < 0, {tag, " R1 R2 load address order"}, act, expv);
        chk(nls == n_exp_c, {tag, " R4 store count"}, nls, n_exp_c);
        bad_i = -1;
        for (int i = 0; i < n_exp_c && i < nls; i++) if (bad_i < 0 && lg_s[i] != exp_c[i]) bad_i = i;
        act = (bad_i < 0) ? 0 : lg_s[bad_i]; expv = (bad_i < 0) ? 0 : exp_c[bad_i];
        chk(bad_i < 0, {tag, " R4 store address order"}, act, expv);
        chk(wr_bad == 0, {tag, " R4 write flag follows kind"}, wr_bad, 0);
        chk(nlab == n_exp_ab, {tag, " R3 A/B count"}, nlab, n_exp_ab);
        bad_i = -1;
        for (int i = 0; i < n_exp_ab && i < nlab; i++)
            if (bad_i < 0 && (lg_ab[i] != exp_ab[i] || lg_abk[i] != exp_abk[i])) bad_i = i;
        act = (bad_i < 0) ? 0 : lg_ab[bad_i]; expv = (bad_i < 0) ? 0 : exp_ab[bad_i];
        chk(bad_i < 0, {tag, " R3 A/B address and kind order"}, act, expv);
        chk(range_bad == 0, {tag, " R5 accesses inside matrices"}, range_bad, 0);
    endtask

    task automatic launch(input int m, input int n, input int k, input int a, input int b, input int c);
        build(m, n, k, a, b, c);
        nlc = 0; nls = 0; nlab = 0; stall_viol = 0; done_beats = 0; wr_bad = 0; range_bad = 0;
        ra = a; rb = b; rc = c; ra_len = m * k; rb_len = k * n; rc_len = m * n;
        @(posedge clk); #1;
        a_base = AW'(a); b_base = AW'(b); c_base = AW'(c);
        m_dim = DW'(m); n_dim = DW'(n); k_dim = DW'(k); start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R9 done low after accepted start", int'(done), 0);
    endtask

    // Wait for completion; stall pattern and mid-job start pulse optional
    task automatic wait_done(input bit stall, input bit poke);
        int w = 0;
        while (!done && w < 20000) begin
            @(posedge clk); #1;
            pe_ready = stall ? ((cyc % 3) != 2) : 1'b1;
            if (poke && w == 10) begin
                start = 1'b1; m_dim = 1; n_dim = 1; k_dim = 1;
                a_base = '0; b_base = '0; c_base = '0;
            end else if (poke && w == 11) begin
                start = 1'b0;
            end
            w++;
        end
        chk(w < 20000, "R9 watchdog: job completes", w, 20000);
        pe_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk(done == 1'b1, "R9 done held until next start", int'(done), 1);
        chk(done_beats == 0, "R9 no access while done", done_beats, 0);
    endtask

    task automatic test_even_tiles();
        launch(8, 8, 3, 100, 400, 700);
        wait_done(1'b0, 1'b0);
        compare_streams("even");
        for (int t = 0; t < n_tiles; t++) begin
            int f, l;
            f = t_abf[t]; l = f + t_abn[t] - 1;
            if (l < nlab)
                chk(lg_abcyc[l] - lg_abcyc[f] == t_abn[t] - 1,
                    "R6 compute burst unbroken while ready", lg_abcyc[l] - lg_abcyc[f], t_abn[t] - 1);
        end
    endtask

    task automatic test_ragged();
        launch(9, 10, 5, 1000, 2000, 3000);
        wait_done(1'b0, 1'b0);
        compare_streams("ragged");
    endtask

    task automatic test_single_word();
        launch(1, 1, 1, 50, 60, 70);
        wait_done(1'b0, 1'b0);
        compare_streams("single");
    endtask

    task automatic test_stall_overlap();
        int inside_st = 0, inside_ld = 0;
        launch(9, 6, 4, 200, 300, 500);
        wait_done(1'b1, 1'b0);
        compare_streams("stall");
        chk(stall_viol == 0, "R8 no A/B while pe_ready low", stall_viol, 0);
        for (int t = 0; t < n_tiles; t++) begin
            int f, l;
            f = t_abf[t]; l = f + t_abn[t] - 1;
            if (l < nlab) begin
                for (int i = 0; i < nls; i++)
                    if (lg_scyc[i] > lg_abcyc[f] && lg_scyc[i] < lg_abcyc[l]) inside_st++;
                for (int i = 0; i < nlc; i++)
                    if (lg_ccyc[i] > lg_abcyc[f] && lg_ccyc[i] < lg_abcyc[l]) inside_ld++;
            end
        end
        chk(inside_st > 0, "R7 stores overlap a compute window", inside_st, 1);
        chk(inside_ld > 0, "R7 loads overlap a compute window", inside_ld, 1);
        for (int t = 2; t < n_tiles; t++) begin
            int ls;
            ls = t_cf[t - 2] + t_cn[t - 2] - 1;
            if (t_cf[t] < nlc && ls < nls)
                chk(lg_ccyc[t_cf[t]] > lg_scyc[ls], "R7 two-tile storage limit",
                    lg_ccyc[t_cf[t]], lg_scyc[ls] + 1);
        end
    endtask

    task automatic test_start_while_busy();
        launch(5, 7, 2, 40, 90, 140);
        wait_done(1'b0, 1'b1);
        compare_streams("busy-start R10");
        chk(nlc == 35, "R10 mid-job start left tile load count", nlc, 35);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R9 reset done low", int'(done), 0);
        chk(mem_valid == 1'b0, "R9 reset port idle", int'(mem_valid), 0);
        test_even_tiles();
        test_ragged();
        test_single_word();
        test_stall_overlap();
        test_start_while_busy();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule